// File: doc/BRIEF.md
# PCI configuration access port decoder

This block sits on a host I/O bus and turns the two-port configuration mechanism into single cycles aimed at a device's configuration space. The host first writes a full 32-bit word to the address port (0xCF8) to select an enable flag, a bus number, a device/function number and a dword register index. It then makes byte, halfword or word reads and writes anywhere in the four-byte data window (0xCFC to 0xCFF).

On each data-window access the block checks the selected target. Valid, present targets receive a one-cycle strobe on a simple downstream configuration interface, carrying bus, device/function, byte offset, length code and write data. Invalid or absent targets see nothing: writes are dropped, and reads return all-ones sized to the access.

A small state machine orders the host side. In `ST_IDLE` the block accepts one access. A read that goes to a device moves to `ST_FETCH` (transition *forward read*) and then to `ST_REPLY` (transition *capture*). A read that the block answers itself (address port, default value, undecoded port) moves directly to `ST_REPLY` (transition *local read*). `ST_REPLY` returns to `ST_IDLE` after one cycle (transition *release*). Writes leave the machine in `ST_IDLE` (transition *write*).

Top module: `cfg_port_bridge`

## Requirements
- R1: A word-size write (size code 2) at port 0xCF8 loads the 32-bit address latch, and a word-size read at port 0xCF8 returns all 32 latched bits. The latch is zero after reset.
- R2: While latch bit 31 is 0, data-window accesses issue no downstream request, and reads return the sized default value.
- R3: While latch bits 1:0 are nonzero, data-window writes issue no request, and reads return the sized default value.
- R4: A forwarded access drives the bus number from latch bits 23:16 and the device/function number from latch bits 15:8.
- R5: The forwarded byte offset is latch bits 7:2 followed by host address bits 1:0. The length code equals the host size code (0 byte, 1 halfword, 2 word), and the write data is passed unchanged.
- R6: A target counts as present only when its bus number is below NUM_BUSES and bit bus*256+devfn of `dev_present` is 1. Accesses to absent targets issue no request, and reads return the sized default value.
- R7: Read data is right-justified and masked to the access width. The sized default value is 0x000000FF for size code 0, 0x0000FFFF for size code 1 and 0xFFFFFFFF for size code 2.
- R8: A forwarded read raises `cfg_req` for exactly the acceptance cycle. The block samples `cfg_rdata` one cycle later, and `io_rvalid` is high during the second cycle after acceptance. Locally answered reads have `io_rvalid` high during the first cycle after acceptance, for one cycle only.
- R9: Address-port accesses that are not word size at exactly 0xCF8 leave the latch unchanged. Reads at 0xCF8 to 0xCFB that are not word size at 0xCF8 return the sized default value.
- R10: `io_ready` is low from the cycle after a read is accepted until its reply cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | Host access request; accepted when `io_ready` is high |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | PORT_AW | Host I/O port address |
| io_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word (3 handled as word) |
| io_wdata | input | 32 | Right-justified write data |
| io_ready | output | 1 | Block can accept an access |
| io_rvalid | output | 1 | Read reply valid this cycle |
| io_rdata | output | 32 | Right-justified read data |
| dev_present | input | NUM_BUSES*256 | Presence bit per bus and device/function |
| cfg_req | output | 1 | One-cycle downstream configuration strobe |
| cfg_we | output | 1 | Downstream write flag |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function number |
| cfg_off | output | 8 | Byte offset inside the configuration space |
| cfg_len | output | 2 | Length code, same encoding as `io_size` |
| cfg_wdata | output | 32 | Right-justified write data |
| cfg_rdata | input | 32 | Device read data, valid one cycle after a read strobe |

## Verification
The bench sweeps every device/function number on both populated buses and on one bus past the range. A fixed presence pattern separates forwarded word reads, which return data encoding the request fields after two cycles, from all-ones replies after one cycle. One present device then gets every combination of low address bits and access size, which shows that offset forming and width masking are done separately. Three further patterns show each suppression path dropping writes and returning sized defaults: enable cleared, misaligned latch, and absent or out-of-range targets. Malformed address-port accesses show that the latch is unaffected.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int DEVFN_W = 8;
    localparam int BUS_W   = 8;
    localparam int DATA_W  = 32;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_REPLY = 2'd2
    } bridge_state_e;

    // All-ones pattern sized to the access; code 3 is treated as a word.
    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgp_port_decode.sv
module cfgp_port_decode #(
    parameter int                 PORT_AW   = 16,
    parameter logic [PORT_AW-1:0] BASE_PORT = 16'hCF8   // must be dword aligned
) (
    input  logic [PORT_AW-1:0] io_addr,
    input  logic               is_word,
    output logic               hit_addr,
    output logic               hit_data
);
    localparam logic [PORT_AW-1:0] DATA_PORT = BASE_PORT + PORT_AW'(4);

    // Latch port only for a full word at the exact base address
    assign hit_addr = (io_addr == BASE_PORT) && is_word;
    // Data window: any byte lane of the following dword
    assign hit_data = (io_addr[PORT_AW-1:2] == DATA_PORT[PORT_AW-1:2]);
endmodule

// File: rtl/cfgp_target_check.sv
module cfgp_target_check
    import cfgp_pkg::*;
#(
    parameter int NUM_BUSES = 2   // power of two, 1..256
) (
    input  logic                          enable,
    input  logic [1:0]                    align_bits,
    input  logic [BUS_W-1:0]              bus,
    input  logic [DEVFN_W-1:0]            devfn,
    input  logic [NUM_BUSES*(1<<DEVFN_W)-1:0] dev_present,
    output logic                          target_ok
);
    localparam int DEVFNS    = 1 << DEVFN_W;
    localparam int PRES_W    = NUM_BUSES * DEVFNS;
    localparam int IDX_W     = $clog2(PRES_W);
    localparam int BUS_SEL_W = (NUM_BUSES > 1) ? $clog2(NUM_BUSES) : 1;

    logic             in_range;
    logic [IDX_W-1:0] idx;

    assign in_range = (int'(bus) < NUM_BUSES);

    generate
        if (NUM_BUSES == 1) begin : g_single_bus
            assign idx = devfn;
        end else begin : g_multi_bus
            assign idx = {bus[BUS_SEL_W-1:0], devfn};
        end
    endgenerate

    assign target_ok = enable && (align_bits == 2'b00) && in_range && dev_present[idx];
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgp_pkg::*;
#(
    parameter int                 PORT_AW   = 16,
    parameter logic [PORT_AW-1:0] BASE_PORT = 16'hCF8,
    parameter int                 NUM_BUSES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          io_valid,
    input  logic                          io_write,
    input  logic [PORT_AW-1:0]            io_addr,
    input  logic [1:0]                    io_size,
    input  logic [31:0]                   io_wdata,
    output logic                          io_ready,
    output logic                          io_rvalid,
    output logic [31:0]                   io_rdata,
    input  logic [NUM_BUSES*256-1:0]      dev_present,
    output logic                          cfg_req,
    output logic                          cfg_we,
    output logic [7:0]                    cfg_bus,
    output logic [7:0]                    cfg_devfn,
    output logic [7:0]                    cfg_off,
    output logic [1:0]                    cfg_len,
    output logic [31:0]                   cfg_wdata,
    input  logic [31:0]                   cfg_rdata
);

    bridge_state_e     state, state_nx;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] rdata_q;
    logic [1:0]        size_q;
    logic              hit_addr, hit_data, target_ok, accept;

    cfgp_port_decode #(.PORT_AW(PORT_AW), .BASE_PORT(BASE_PORT)) u_decode (
        .io_addr  (io_addr),
        .is_word  (io_size[1]),
        .hit_addr (hit_addr),
        .hit_data (hit_data)
    );

    cfgp_target_check #(.NUM_BUSES(NUM_BUSES)) u_check (
        .enable      (addr_q[31]),
        .align_bits  (addr_q[1:0]),
        .bus         (addr_q[23:16]),
        .devfn       (addr_q[15:8]),
        .dev_present (dev_present),
        .target_ok   (target_ok)
    );

    assign accept = io_valid && (state == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: write, local read, forward read, capture, release
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept && !io_write)
                    state_nx = (hit_data && target_ok) ? ST_FETCH : ST_REPLY;
            end
            ST_FETCH: state_nx = ST_REPLY;
            ST_REPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        io_ready  = 1'b0;
        io_rvalid = 1'b0;
        cfg_req   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                io_ready = 1'b1;
                cfg_req  = io_valid && hit_data && target_ok;
            end
            ST_FETCH: ;
            ST_REPLY: io_rvalid = 1'b1;
            default: ;
        endcase
    end

    assign cfg_we    = io_write;
    assign cfg_bus   = addr_q[23:16];
    assign cfg_devfn = addr_q[15:8];
    assign cfg_off   = {addr_q[7:2], io_addr[1:0]};
    assign cfg_len   = io_size;
    assign cfg_wdata = io_wdata;
    assign io_rdata  = rdata_q;

    // Address latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            addr_q <= '0;
        else if (accept && io_write && hit_addr) addr_q <= io_wdata;
    end

    // Read reply data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            size_q  <= SZ_BYTE;
        end else if (accept && !io_write) begin
            size_q  <= io_size;
            rdata_q <= hit_addr ? addr_q : width_mask(io_size);
        end else if (state == ST_FETCH) begin
            rdata_q <= cfg_rdata & width_mask(size_q);
        end
    end

    // R1: latch changes only on an accepted write
    p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_valid && io_ready && io_write) |=> $stable(addr_q));
    // R2: requests need the enable bit
    p_req_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> addr_q[31]);
    // R3: requests need a dword-aligned latch
    p_req_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (addr_q[1:0] == 2'b00));
    // R5: offset upper bits come from the latch register index
    p_off_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (cfg_off[7:2] == addr_q[7:2]));
    // R7: byte replies carry nothing above bit 7
    p_byte_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rvalid && size_q == SZ_BYTE) |-> (io_rdata[31:8] == 24'd0));
    // R8: forwarded read waits one cycle, strobe not repeated
    p_fetch_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_we) |=> (state == ST_FETCH && !cfg_req));
    // R8: reply lasts one cycle
    p_reply_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |=> !io_rvalid);
    // R10: no acceptance while a reply is shown
    p_busy_reply_r10: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |-> !io_ready);

endmodule

// File: tb/test_cfg_port_bridge.sv
module test_cfg_port_bridge;

    localparam int NB = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0, io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic        io_ready, io_rvalid;
    logic [31:0] io_rdata;
    logic [NB*256-1:0] dev_present;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_bus, cfg_devfn, cfg_off;
    logic [1:0]  cfg_len;
    logic [31:0] cfg_wdata;
    logic [31:0] dev_rdata = '0;

    int total = 0, bad = 0, req_cnt = 0;
    logic [7:0]  last_bus, last_devfn, last_off;
    logic [1:0]  last_len;
    logic        last_we;
    logic [31:0] last_wdata;

    always #5 clk = ~clk;

    cfg_port_bridge #(.NUM_BUSES(NB)) i_cfg_port_bridge (
        .clk(clk), .rst_n(rst_n),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
        .io_size(io_size), .io_wdata(io_wdata),
        .io_ready(io_ready), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .dev_present(dev_present),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus),
        .cfg_devfn(cfg_devfn), .cfg_off(cfg_off), .cfg_len(cfg_len),
        .cfg_wdata(cfg_wdata), .cfg_rdata(dev_rdata)
    );

    // Device model and request monitor
    always @(posedge clk) begin
        if (cfg_req) begin
            req_cnt    <= req_cnt + 1;
            last_bus   <= cfg_bus;
            last_devfn <= cfg_devfn;
            last_off   <= cfg_off;
            last_len   <= cfg_len;
            last_we    <= cfg_we;
            last_wdata <= cfg_wdata;
            if (!cfg_we) dev_rdata <= {cfg_bus, cfg_devfn, cfg_off, 6'd0, cfg_len};
        end
    end

    function automatic bit pres(int b, int d);
        if (b == 0) return (d % 8 == 0) && ((d / 8) % 3 != 1);
        if (b == 1) return (d % 5 == 0);
        return 1'b0;
    endfunction

    function automatic logic [31:0] msk(logic [1:0] sz);
        if (sz == 2'd0) return 32'h0000_00FF;
        if (sz == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [15:0] p, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int lat, output logic rdy1);
        @(negedge clk);
        while (!io_ready) @(negedge clk);
        io_valid = 1'b1; io_write = we; io_addr = p; io_size = sz; io_wdata = wd;
        @(negedge clk);
        io_valid = 1'b0;
        lat = 1; rdy1 = io_ready; rd = '0;
        if (!we) begin
            while (!io_rvalid && lat < 8) begin
                @(negedge clk);
                lat++;
            end
            rd = io_rdata;
        end
    endtask

    task automatic set_addr(input logic [31:0] v);
        logic [31:0] rd; int lat; logic r1;
        access(1'b1, 16'hCF8, 2'd2, v, rd, lat, r1);
    endtask

    bit finished = 0;

    initial begin
        logic [31:0] rd, exp;
        int lat, n0;
        logic r1;
        logic [7:0] reg8;

        for (int b = 0; b < NB; b++)
            for (int d = 0; d < 256; d++)
                dev_present[b*256+d] = pres(b, d);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        chk("R10 ready after reset", {31'd0, io_ready}, 32'd1);
        chk("R8 no reply after reset", {31'd0, io_rvalid}, 32'd0);
        access(1'b0, 16'hCF8, 2'd2, '0, rd, lat, r1);
        chk("R1 latch reset value", rd, 32'd0);

        // Latch write/read back, including low bits
        set_addr(32'h8012_3457);
        access(1'b0, 16'hCF8, 2'd2, '0, rd, lat, r1);
        chk("R1 latch readback", rd, 32'h8012_3457);
        chk("R8 local read latency", lat, 1);

        // Sweep of targets
        for (int b = 0; b < 3; b++) begin
            for (int d = 0; d < 256; d++) begin
                reg8 = 8'((d * 4) & 252);
                set_addr(32'h8000_0000 | (b << 16) | (d << 8) | reg8);
                n0 = req_cnt;
                access(1'b0, 16'hCFC, 2'd2, '0, rd, lat, r1);
                if (pres(b, d)) begin
                    exp = {8'(b), 8'(d), reg8, 8'h02};
                    chk("R6 present read data", rd, exp);
                    chk("R8 forwarded latency", lat, 2);
                    chk("R4 bus field", {24'd0, last_bus}, 32'(b));
                    chk("R4 devfn field", {24'd0, last_devfn}, 32'(d));
                    chk("R6 one request", req_cnt - n0, 1);
                end else begin
                    chk("R6 absent read default", rd, 32'hFFFF_FFFF);
                    chk("R8 default latency", lat, 1);
                    chk("R6 no request", req_cnt - n0, 0);
                end
            end
        end

        // Offset and width sweep on bus 0 devfn 0
        set_addr(32'h8000_0044);
        for (int lo = 0; lo < 4; lo++) begin
            for (int sz = 0; sz < 3; sz++) begin
                access(1'b0, 16'hCFC + 16'(lo), 2'(sz), '0, rd, lat, r1);
                exp = {16'h0000, 8'h44 | 8'(lo), 6'd0, 2'(sz)} & msk(2'(sz));
                chk("R7 masked read data", rd, exp);
                chk("R5 offset", {24'd0, last_off}, 32'h44 | 32'(lo));
                chk("R5 length code", {30'd0, last_len}, 32'(sz));
                chk("R10 busy after read", {31'd0, r1}, 32'd0);
            end
        end

        // Enable bit cleared
        set_addr(32'h0000_0044);
        for (int sz = 0; sz < 3; sz++) begin
            n0 = req_cnt;
            access(1'b0, 16'hCFC, 2'(sz), '0, rd, lat, r1);
            chk("R2 disabled read default", rd, msk(2'(sz)));
            chk("R7 sized default", rd, msk(2'(sz)));
            access(1'b1, 16'hCFC, 2'(sz), 32'h1234_5678, rd, lat, r1);
            chk("R2 disabled no request", req_cnt - n0, 0);
        end

        // Misaligned latch
        for (int lo = 1; lo < 4; lo++) begin
            set_addr(32'h8000_0044 | 32'(lo));
            n0 = req_cnt;
            access(1'b0, 16'hCFC, 2'd2, '0, rd, lat, r1);
            chk("R3 misaligned read default", rd, 32'hFFFF_FFFF);
            access(1'b1, 16'hCFC, 2'd0, 32'h0000_00AA, rd, lat, r1);
            chk("R3 misaligned no request", req_cnt - n0, 0);
        end

        // Forwarded write: bus 1 devfn 10 present
        set_addr(32'h8001_0A40);
        n0 = req_cnt;
        access(1'b1, 16'hCFE, 2'd1, 32'h0000_BEEF, rd, lat, r1);
        chk("R5 write request count", req_cnt - n0, 1);
        chk("R5 write flag", {31'd0, last_we}, 32'd1);
        chk("R4 write bus", {24'd0, last_bus}, 32'd1);
        chk("R4 write devfn", {24'd0, last_devfn}, 32'h0A);
        chk("R5 write offset", {24'd0, last_off}, 32'h42);
        chk("R5 write length", {30'd0, last_len}, 32'd1);
        chk("R5 write data", last_wdata, 32'h0000_BEEF);

        // Absent and out-of-range writes
        set_addr(32'h8001_0B40);
        n0 = req_cnt;
        access(1'b1, 16'hCFC, 2'd2, 32'hDEAD_BEEF, rd, lat, r1);
        set_addr(32'h8002_0000);
        access(1'b1, 16'hCFC, 2'd2, 32'hDEAD_BEEF, rd, lat, r1);
        chk("R6 absent writes dropped", req_cnt - n0, 0);

        // Malformed address-port accesses
        set_addr(32'h8000_1234);
        access(1'b1, 16'hCF9, 2'd2, 32'hFFFF_FFFF, rd, lat, r1);
        access(1'b1, 16'hCF8, 2'd0, 32'h0000_0055, rd, lat, r1);
        access(1'b1, 16'hCF8, 2'd1, 32'h0000_5555, rd, lat, r1);
        access(1'b0, 16'hCF8, 2'd2, '0, rd, lat, r1);
        chk("R9 latch unchanged", rd, 32'h8000_1234);
        access(1'b0, 16'hCF8, 2'd0, '0, rd, lat, r1);
        chk("R9 byte read at latch port", rd, 32'h0000_00FF);
        access(1'b0, 16'hCFA, 2'd2, '0, rd, lat, r1);
        chk("R9 read at unused port", rd, 32'hFFFF_FFFF);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule